// File: doc/BRIEF.md
# Cascadable Stereo TDM Serializer

This block turns one stereo sample pair into a serial bit stream for a time-division-multiplexed link into a processor serial port. On every frame pulse, sampled on the bit clock, it captures a left and a right word side by side into one internal shift register. It then moves that register one place per bit clock, with the most significant bit first and the left word ahead of the right word.

The serial input sits at the bottom of the register. Instances can therefore be wired output-to-input into a single long chain that shares the bit clock and the frame pulse. With N instances in the chain, one frame is N times the register width in bit clocks. The processor end receives the instance nearest to it first, then each instance further upstream in turn.

A small controller tracks the frame. The states are named as follows:
- IDLE: the state after reset. Nothing has been loaded, and the register holds still.
- OWN: the instance's own bits are leaving.
- RELAY: the own bits are gone, and the register only forwards upstream data.

The transitions are named as follows:
- *load*: the frame pulse, taken from any state into OWN.
- *drain*: OWN to RELAY, on the shift that sends the last own bit.
- *hold*: staying in RELAY or IDLE.

Top module: `tdm_chain_serializer`

## Requirements
- R1: While `rst_n` is low, `chain_out` is 0 and the register is cleared. This holds even if `chain_in` toggles, and even if reset arrives in the middle of a frame.
- R2: A bit-clock edge with `frame_pulse` high loads `{left_word, right_word}` into the register. From that edge on, `chain_out` shows bit SAMPLE_W-1 of `left_word`.
- R3: After a load, the next 2×SAMPLE_W bits on `chain_out` are the left word and then the right word, each with the most significant bit first. One bit is presented per bit clock.
- R4: A `chain_in` value sampled on a shift edge appears on `chain_out` exactly 2×SAMPLE_W bit clocks later. So once the own bits are gone, the upstream data follows without a gap.
- R5: When `frame_pulse` is high, the load wins over the shift. A frame pulse in the middle of a frame restarts the output with the new words, and the `chain_in` bit present at that edge is discarded.
- R6: After reset and before the first frame pulse (state IDLE), the register does not shift. `chain_out` stays 0 whatever `chain_in` does.
- R7: Three instances are chained, with each `chain_out` wired to the next `chain_in` and a shared pulse. After one load, the last instance's output delivers the last instance's 64 bits, then the middle instance's 64 bits, then the first instance's 64 bits.
- R8: Frame pulses on consecutive edges reload on every edge. Only the words present at the final pulse are shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_pulse | input | 1 | Frame start, sampled on bclk |
| left_word | input | SAMPLE_W | Left sample, loaded into the upper half |
| right_word | input | SAMPLE_W | Right sample, loaded into the lower half |
| chain_in | input | 1 | Serial input from the upstream instance |
| chain_out | output | 1 | Serial output to the downstream instance or the processor |

## Verification
A corrupted register bit shows on `chain_out` at a fixed position: at the bit clock that matches its distance from the top of the register. Checking every bit of a frame therefore locates the bad bit to the cycle.

A controller that never leaves IDLE, or that lets IDLE shift, shows on the first frame or on the first upstream '1', respectively. A shift that wins over a load shows one bit clock after a mid-frame pulse, as a wrong most significant bit. A broken chain link appears only in the cascade, one whole instance width into the frame.

// File: rtl/tdm_chain_pkg.sv
package tdm_chain_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OWN   = 2'd1,
        ST_RELAY = 2'd2
    } chain_state_e;

endpackage

// File: rtl/tdm_frame_fsm.sv
module tdm_frame_fsm
    import tdm_chain_pkg::*;
#(
    parameter int FRAME_W = 64
) (
    input  logic         bclk,
    input  logic         rst_n,
    input  logic         frame_pulse,
    output logic         load_en,
    output logic         shift_en,
    output chain_state_e state_o
);

    localparam int              CNT_W    = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

    chain_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state: load has priority from every state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (frame_pulse) begin
            state_d = ST_OWN;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_OWN: begin
                    if (cnt_q == LAST_BIT) begin
                        state_d = ST_RELAY;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_RELAY: state_d = ST_RELAY;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        load_en = frame_pulse;
        unique case (state_q)
            ST_IDLE:  shift_en = 1'b0;
            ST_OWN:   shift_en = !frame_pulse;
            ST_RELAY: shift_en = !frame_pulse;
            default:  shift_en = 1'b0;
        endcase
    end

    assign state_o = state_q;

    // R5
    load_restart_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        frame_pulse |=> (state_q == ST_OWN && cnt_q == '0));

    // R4
    relay_entry_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        (state_q == ST_RELAY && $past(state_q) == ST_OWN) |-> ($past(cnt_q) == LAST_BIT));

    // R6
    no_return_idle_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/tdm_load_shifter.sv
module tdm_load_shifter #(
    parameter int SAMPLE_W = 32
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic                shift_en,
    input  logic [SAMPLE_W-1:0] left_word,
    input  logic [SAMPLE_W-1:0] right_word,
    input  logic                ser_in,
    output logic                ser_out
);

    localparam int FRAME_W = 2 * SAMPLE_W;

    logic [FRAME_W-1:0] par_word;
    logic [FRAME_W-1:0] sr_q;

    assign par_word = {left_word, right_word};

    for (genvar gi = 0; gi < FRAME_W; gi++) begin : g_stage
        logic feed;
        if (gi == 0) begin : g_head
            assign feed = ser_in;
        end else begin : g_body
            assign feed = sr_q[gi-1];
        end

        always_ff @(posedge bclk or negedge rst_n) begin
            if (!rst_n)        sr_q[gi] <= 1'b0;
            else if (load_en)  sr_q[gi] <= par_word[gi];
            else if (shift_en) sr_q[gi] <= feed;
        end
    end

    assign ser_out = sr_q[FRAME_W-1];

    // R2
    load_capture_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        load_en |=> (sr_q == $past(par_word)));

    // R3
    shift_step_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        (shift_en && !load_en) |=> (sr_q[FRAME_W-1:1] == $past(sr_q[FRAME_W-2:0])));

    // R4
    tail_entry_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        (shift_en && !load_en) |=> (sr_q[0] == $past(ser_in)));

    // R6
    hold_still_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        (!shift_en && !load_en) |=> $stable(sr_q));

endmodule

// File: rtl/tdm_chain_serializer.sv
module tdm_chain_serializer
    import tdm_chain_pkg::*;
#(
    parameter int SAMPLE_W = 32
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                frame_pulse,
    input  logic [SAMPLE_W-1:0] left_word,
    input  logic [SAMPLE_W-1:0] right_word,
    input  logic                chain_in,
    output logic                chain_out
);

    localparam int FRAME_W = 2 * SAMPLE_W;

    logic         load_en;
    logic         shift_en;
    chain_state_e state;

    tdm_frame_fsm #(
        .FRAME_W (FRAME_W)
    ) u_fsm (
        .bclk        (bclk),
        .rst_n       (rst_n),
        .frame_pulse (frame_pulse),
        .load_en     (load_en),
        .shift_en    (shift_en),
        .state_o     (state)
    );

    tdm_load_shifter #(
        .SAMPLE_W (SAMPLE_W)
    ) u_shifter (
        .bclk       (bclk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .shift_en   (shift_en),
        .left_word  (left_word),
        .right_word (right_word),
        .ser_in     (chain_in),
        .ser_out    (chain_out)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge bclk)
        !rst_n |-> (chain_out == 1'b0));

    // R2
    msb_first_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        frame_pulse |=> (chain_out == $past(left_word[SAMPLE_W-1])));

    // R6
    idle_zero_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        (state == ST_IDLE && !frame_pulse) |=> (chain_out == 1'b0));

endmodule

// File: tb/tdm_chain_serializer_tb.sv
module tdm_chain_serializer_tb;

    localparam int SW = 32;
    localparam int FW = 2 * SW;

    logic          bclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_pulse = 1'b0;
    logic [SW-1:0] left_word = '0;
    logic [SW-1:0] right_word = '0;
    logic          chain_in = 1'b0;
    logic          chain_out;

    logic [SW-1:0] c_left  [3];
    logic [SW-1:0] c_right [3];
    logic          c_head = 1'b0;
    logic          link01, link12, proc_in;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 bclk = ~bclk;

    tdm_chain_serializer #(.SAMPLE_W(SW)) u_dut (
        .bclk(bclk), .rst_n(rst_n), .frame_pulse(frame_pulse),
        .left_word(left_word), .right_word(right_word),
        .chain_in(chain_in), .chain_out(chain_out));

    tdm_chain_serializer #(.SAMPLE_W(SW)) u_c0 (
        .bclk(bclk), .rst_n(rst_n), .frame_pulse(frame_pulse),
        .left_word(c_left[0]), .right_word(c_right[0]),
        .chain_in(c_head), .chain_out(link01));
    tdm_chain_serializer #(.SAMPLE_W(SW)) u_c1 (
        .bclk(bclk), .rst_n(rst_n), .frame_pulse(frame_pulse),
        .left_word(c_left[1]), .right_word(c_right[1]),
        .chain_in(link01), .chain_out(link12));
    tdm_chain_serializer #(.SAMPLE_W(SW)) u_c2 (
        .bclk(bclk), .rst_n(rst_n), .frame_pulse(frame_pulse),
        .left_word(c_left[2]), .right_word(c_right[2]),
        .chain_in(link12), .chain_out(proc_in));

    task automatic tick();
        @(negedge bclk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // load with one pulse; returns at the negedge where bit 0 is visible
    task automatic pulse_load(input logic [SW-1:0] l, input logic [SW-1:0] r);
        left_word   = l;
        right_word  = r;
        frame_pulse = 1'b1;
        tick();
        frame_pulse = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            chain_in = i[0];
            tick();
            chk("R1 reset output", chain_out, 1'b0);
        end
        chain_in = 1'b0;
    endtask

    task automatic t_idle();
        rst_n    = 1'b1;
        chain_in = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick();
            chk("R6 idle output", chain_out, 1'b0);
        end
        chain_in = 1'b0;
    endtask

    task automatic t_frame();
        logic [FW-1:0] exp_own = 64'hA5C3_0F96_1E2D_7B48;
        logic [FW-1:0] pat     = 64'h3C5A_9617_E001_FFB2;
        pulse_load(exp_own[FW-1:SW], exp_own[SW-1:0]);
        chk("R2 first bit", chain_out, exp_own[FW-1]);
        for (int k = 0; k < 2 * FW; k++) begin
            if (k < FW) chk("R3 own bit", chain_out, exp_own[FW-1-k]);
            else        chk("R4 relayed bit", chain_out, pat[FW-1-(k-FW)]);
            chain_in = (k < FW) ? pat[FW-1-k] : 1'b0;
            tick();
        end
        chain_in = 1'b0;
    endtask

    task automatic t_priority();
        logic [FW-1:0] b_word = 64'h7E81_2244_C3C3_0001;
        pulse_load(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        repeat (10) tick();
        chain_in = 1'b1;
        pulse_load(b_word[FW-1:SW], b_word[SW-1:0]);
        chain_in = 1'b0;
        for (int k = 0; k <= FW; k++) begin
            if (k < FW) chk("R5 reload bit", chain_out, b_word[FW-1-k]);
            else        chk("R5 discarded chain_in", chain_out, 1'b0);
            tick();
        end
    endtask

    task automatic t_back2back();
        logic [FW-1:0] w [3];
        w[0] = 64'h8000_0001_0000_00FF;
        w[1] = 64'h1234_5678_9ABC_DEF0;
        w[2] = 64'hC001_D00D_0BAD_F00D;
        frame_pulse = 1'b1;
        for (int j = 0; j < 3; j++) begin
            left_word  = w[j][FW-1:SW];
            right_word = w[j][SW-1:0];
            tick();
            chk("R8 reload msb", chain_out, w[j][FW-1]);
        end
        frame_pulse = 1'b0;
        for (int k = 0; k < FW; k++) begin
            chk("R8 final word bit", chain_out, w[2][FW-1-k]);
            tick();
        end
    endtask

    task automatic t_mid_reset();
        pulse_load(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        repeat (3) tick();
        #2 rst_n = 1'b0;
        #2 chk("R1 async clear", chain_out, 1'b0);
        tick();
        chk("R1 held clear", chain_out, 1'b0);
        rst_n = 1'b1;
        tick();
    endtask

    task automatic t_cascade();
        logic [3*FW-1:0] stream;
        c_left[0] = 32'h0102_0304; c_right[0] = 32'hF0E0_D0C0;
        c_left[1] = 32'hAAAA_5555; c_right[1] = 32'h0F0F_F0F0;
        c_left[2] = 32'h8421_1248; c_right[2] = 32'h7FFF_0000;
        stream = {c_left[2], c_right[2], c_left[1], c_right[1], c_left[0], c_right[0]};
        pulse_load(32'h0, 32'h0);
        for (int k = 0; k < 3 * FW; k++) begin
            chk("R7 chain bit", proc_in, stream[3*FW-1-k]);
            tick();
        end
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            c_left[i]  = '0;
            c_right[i] = '0;
        end
        tick();
        t_reset();
        t_idle();
        t_frame();
        t_priority();
        t_back2back();
        t_mid_reset();
        t_cascade();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge bclk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

endmodule